// File: doc/BRIEF.md
# Scan Chain Integrity Checker

This block is a host-side controller for a serial chain of test access port devices. On a start strobe it takes the chain through a forced reset, walks the port state machines into the data-register shift state without loading any instruction, and shifts the whole chain out once with a zero fill. After that forced reset, each device sits in its power-on register: a 32-bit identity word, or a single bypass bit on devices that lack one.

The shifted stream arrives least significant bit first, starting with the device nearest the chain's output pin. It is split into per-device fields using a compile-time table of field lengths. Each field is compared with an expected word under a compare mask, so that don't-care bits (for example an identity word's version nibble) are left out. At the end of the pass the block reports an overall pass flag and one fail bit per device. It also reports the index of the first failing device. An open connection in the chain forces every field on the input side of the break to read as all ones, so that index also locates the break: it lies on the input side of the last matching device.

The test clock is divided down from the system clock. Its half period is rounded up to a whole number of system cycles, so its rate never exceeds the configured ceiling.

Top module: `scan_chain_probe`

## Requirements
- R1: While reset is held and after its release, tck_o is 0, tms_o is 1, tdi_o is 0, done_o and pass_o are 0, fail_o is all zeros and break_idx_o equals NDEV (3 by default).
- R2: Each test clock level lasts HALF system cycles, with HALF = ceil(SYS_HZ / (2 * TCK_MAX_HZ)). The defaults of 250 MHz and 4.5 MHz give HALF = 28, so the rising edges are 56 system cycles apart.
- R3: Every pass presents exactly 76 rising test clock edges, and tms_o changes only while tck_o is low. The TMS values at those edges are, in order: five 1s, then 0, 1, 0, 0, then 64 0s and a 1 (the shift phase), then 1, 0. The chain's port state machines finish in Run-Test/Idle.
- R4: tdi_o is 0 at every rising test clock edge.
- R5: tdo_i is sampled at the 65 rising edges spent in the shift state, and only there. The first sample is bit 0 of device 0, the device nearest the output pin.
- R6: Field d covers DEV_LEN[d] consecutive samples, fields in device order. A sample is compared with DEV_EXP[d] only where DEV_MASK[d] holds a 1; bits under a 0 mask never cause a failure. Defaults: device 0 is 32 bits, expected 0x1000502F, mask 0xFFFFFFFF. Device 1 is 1 bit, expected 0, mask 1. Device 2 is 32 bits, expected 0x09504093, mask 0x0FFFFFFF.
- R7: At the end of a pass, fail_o[d] is 1 exactly when field d had a compared mismatch. pass_o is 1 exactly when no field failed.
- R8: break_idx_o is the lowest index d with fail_o[d] = 1, or NDEV when no field failed. An open link between device d-1 and device d therefore gives break_idx_o = d.
- R9: done_o rises on the falling test clock edge that follows the last rising edge. It then stays high, with tck_o parked low and the results held, until the next accepted start.
- R10: A start strobe that arrives while a pass is running is ignored; that pass still presents exactly 76 rising edges.
- R11: An accepted start clears done_o, pass_o and fail_o, and sets break_idx_o to NDEV, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a pass when idle |
| tdo_i | input | 1 | Serial data returned by the chain |
| tck_o | output | 1 | Test clock to the chain |
| tms_o | output | 1 | Test mode select to the chain |
| tdi_o | output | 1 | Serial data into the chain (zero fill) |
| done_o | output | 1 | Pass finished; results valid |
| pass_o | output | 1 | Every field matched under its mask |
| fail_o | output | NDEV | One mismatch flag per device, bit 0 nearest the output pin |
| break_idx_o | output | $clog2(NDEV+1) | First failing device, NDEV when none |

## Verification
The hardest situation to reach is an open link in the middle of the chain, where the devices before the break return correct data and every field after it turns to ones. The bench holds a behavioural model of the chain's port state machines and shift register. That model can cut the chain at any link, so that the cut-off bits and the shift input both read high, and it can also replace any device's captured word. Scenarios cover an intact chain, cuts at the output pin and at each inner link, a version-nibble difference that must be masked out, and a single flipped compared bit. The expected flags are worked out from the requirement's table, independently of the block.

// File: rtl/scp_pkg.sv
// Package: shared types and constant helpers for the scan chain checker.
// Assumes: callers pass positive clock rates.
package scp_pkg;

    // Walker phases; each names the TMS level presented for the next rising edge.
    typedef enum logic [3:0] {
        W_IDLE,
        W_RESET,
        W_RTI,
        W_SEL,
        W_CAP,
        W_ENTER,
        W_SHIFT,
        W_EXIT,
        W_UPDATE,
        W_PARK
    } walk_e;

    // Half period in system cycles, rounded up so the test clock never runs fast.
    function automatic int unsigned half_period(longint unsigned sys_hz,
                                                longint unsigned max_hz);
        longint unsigned q;
        q = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        if (q < 1) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/scp_tck_div.sv
// Module: test clock divider.
// Produces a square test clock whose levels last HALF system cycles while en_i
// is high. It gives one-cycle rise/fall strobes that line up with the system
// edge at which tck_o changes. When disabled it parks the clock low.
// Assumes: en_i drops only on the cycle of a fall strobe, or while idle.
module scp_tck_div #(
    parameter int unsigned HALF = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;
    logic          tck_q;
    logic          wrap;

    assign wrap   = (cnt_q == CW'(HALF - 1));
    assign rise_o = en_i && wrap && !tck_q;
    assign fall_o = en_i && wrap && tck_q;
    assign tck_o  = tck_q;

    // Count out each level and toggle the clock at the end of it.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Checker state: cycles the previous clock level lasted (saturating).
    logic          tck_prev_q;
    logic [CW-1:0] gap_q;
    logic          toggled;
    assign toggled = (tck_q != tck_prev_q);

    // Track the previous level and how long the level before a toggle lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_prev_q <= 1'b0;
            gap_q      <= CW'(HALF);
        end else begin
            tck_prev_q <= tck_q;
            if (toggled)
                gap_q <= CW'(1);
            else if (gap_q != CW'(HALF))
                gap_q <= gap_q + 1'b1;
        end
    end

    // R2: no clock level is shorter than HALF system cycles.
    p_level_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        toggled |-> gap_q == CW'(HALF));

endmodule

// File: rtl/scp_tap_walker.sv
// Module: port state walker.
// Steps the chain through forced reset, Run-Test/Idle, a data-register capture,
// TOTAL shift cycles, Update-DR and back to Run-Test/Idle. It advances on each
// rising test clock edge and moves TMS on the falling edge that follows.
// Assumes: rise_i and fall_i are never high in the same cycle.
module scp_tap_walker
    import scp_pkg::*;
#(
    parameter int unsigned TOTAL     = 65,
    parameter int unsigned RESET_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic busy_o,
    output logic tms_o,
    output logic bit_vld_o,
    output logic clear_o,
    output logic finish_o
);
    localparam int unsigned BIGGEST = (TOTAL > RESET_CYC) ? TOTAL : RESET_CYC;
    localparam int CW = $clog2(BIGGEST + 1);

    walk_e         st_q;
    logic [CW-1:0] cnt_q;
    logic          tms_q;
    logic          tms_next;

    // TMS level the current phase must present at the coming rising edge.
    always_comb begin
        unique case (st_q)
            W_IDLE:   tms_next = 1'b1;
            W_RESET:  tms_next = 1'b1;
            W_RTI:    tms_next = 1'b0;
            W_SEL:    tms_next = 1'b1;
            W_CAP:    tms_next = 1'b0;
            W_ENTER:  tms_next = 1'b0;
            W_SHIFT:  tms_next = (cnt_q == CW'(TOTAL - 1));
            W_EXIT:   tms_next = 1'b1;
            W_UPDATE: tms_next = 1'b0;
            W_PARK:   tms_next = 1'b0;
            default:  tms_next = 1'b1;
        endcase
    end

    // Phase sequencing on rising edges, TMS updates on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= W_IDLE;
            cnt_q <= '0;
            tms_q <= 1'b1;
        end else if (st_q == W_IDLE) begin
            if (start_i) begin
                st_q  <= W_RESET;
                cnt_q <= '0;
                tms_q <= 1'b1;
            end
        end else if (rise_i) begin
            unique case (st_q)
                W_RESET: begin
                    if (cnt_q == CW'(RESET_CYC - 1)) begin
                        st_q  <= W_RTI;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                W_RTI:   st_q <= W_SEL;
                W_SEL:   st_q <= W_CAP;
                W_CAP:   st_q <= W_ENTER;
                W_ENTER: begin
                    st_q  <= W_SHIFT;
                    cnt_q <= '0;
                end
                W_SHIFT: begin
                    if (cnt_q == CW'(TOTAL - 1)) begin
                        st_q  <= W_EXIT;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                W_EXIT:   st_q <= W_UPDATE;
                W_UPDATE: st_q <= W_PARK;
                default:  st_q <= st_q;
            endcase
        end else if (fall_i) begin
            tms_q <= tms_next;
            if (st_q == W_PARK)
                st_q <= W_IDLE;
        end
    end

    assign busy_o    = (st_q != W_IDLE);
    assign tms_o     = tms_q;
    assign bit_vld_o = rise_i && (st_q == W_SHIFT);
    assign clear_o   = (st_q == W_IDLE) && start_i;
    assign finish_o  = (st_q == W_PARK) && fall_i;

    // R3: throughout the forced reset phase the select line stays high.
    p_reset_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == W_RESET) |-> tms_q);

endmodule

// File: rtl/scp_field_check.sv
// Module: per-device field comparator.
// Splits the sampled stream into consecutive fields of DEV_LEN bits (device 0
// first), compares each bit under its mask and latches the flags, the pass
// result and the lowest failing index when the pass finishes.
// Assumes: exactly sum(DEV_LEN) bits arrive between clear_i and finish_i.
module scp_field_check #(
    parameter int unsigned NDEV = 3,
    parameter int unsigned MAXW = 32,
    parameter int unsigned LENW = 8,
    parameter int unsigned IW   = 2,
    parameter logic [NDEV-1:0][LENW-1:0] DEV_LEN  = '0,
    parameter logic [NDEV-1:0][MAXW-1:0] DEV_EXP  = '0,
    parameter logic [NDEV-1:0][MAXW-1:0] DEV_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            bit_vld_i,
    input  logic            bit_i,
    input  logic            finish_i,
    output logic [NDEV-1:0] fail_o,
    output logic            pass_o,
    output logic [IW-1:0]   brk_o
);
    localparam int PW = (MAXW > 1) ? $clog2(MAXW) : 1;

    logic [IW-1:0]   dev_q;
    logic [PW-1:0]   pos_q;
    logic [NDEV-1:0] mism_q;
    logic [NDEV-1:0] fail_q;
    logic            pass_q;
    logic [IW-1:0]   brk_q;
    logic [IW-1:0]   sel;
    logic            in_range;
    logic            last_bit;
    logic            miss;
    logic [IW-1:0]   first_idx;

    // Select the active field's table entry and judge the incoming bit.
    always_comb begin
        in_range = (dev_q < IW'(NDEV));
        sel      = in_range ? dev_q : '0;
        last_bit = (LENW'(pos_q) + LENW'(1) == DEV_LEN[sel]);
        miss     = DEV_MASK[sel][pos_q] && (bit_i != DEV_EXP[sel][pos_q]);
    end

    // Lowest failing device, NDEV when every field matched.
    always_comb begin
        first_idx = IW'(NDEV);
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (mism_q[i]) first_idx = IW'(i);
        end
    end

    // Walk the fields, accumulate mismatches and latch results at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            dev_q  <= '0;
            pos_q  <= '0;
            mism_q <= '0;
            fail_q <= '0;
            pass_q <= 1'b0;
            brk_q  <= IW'(NDEV);
        end else if (bit_vld_i && in_range) begin
            if (miss) mism_q[sel] <= 1'b1;
            if (last_bit) begin
                dev_q <= dev_q + 1'b1;
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end else if (finish_i) begin
            fail_q <= mism_q;
            pass_q <= (mism_q == '0);
            brk_q  <= first_idx;
        end
    end

    assign fail_o = fail_q;
    assign pass_o = pass_q;
    assign brk_o  = brk_q;

    // R6: the walker never supplies more bits than the table describes.
    p_bits_in_table_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_i |-> in_range);

    // R7: a pass result never coexists with a raised device flag.
    p_pass_means_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (fail_o == '0));

    // R8: a reported break index always points at a failing device.
    p_break_is_failing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_o < IW'(NDEV)) |-> fail_o[brk_o]);

endmodule

// File: rtl/scan_chain_probe.sv
// Module: scan chain integrity checker (top).
// On start, runs one default data-register pass over the whole chain with a
// zero fill, checks every device field against its masked expectation and
// reports per-device flags, a pass flag and the first failing index.
// Assumes: the chain drives tdo_i on falling test clock edges; device 0 is
// nearest the chain output.
module scan_chain_probe
    import scp_pkg::*;
#(
    parameter int unsigned NDEV       = 3,
    parameter int unsigned MAXW       = 32,
    parameter int unsigned LENW       = 8,
    parameter logic [NDEV-1:0][LENW-1:0] DEV_LEN  = {8'd32, 8'd1, 8'd32},
    parameter logic [NDEV-1:0][MAXW-1:0] DEV_EXP  = {32'h09504093, 32'h00000000, 32'h1000502F},
    parameter logic [NDEV-1:0][MAXW-1:0] DEV_MASK = {32'h0FFFFFFF, 32'h00000001, 32'hFFFFFFFF},
    parameter longint unsigned SYS_HZ     = 250_000_000,
    parameter longint unsigned TCK_MAX_HZ = 4_500_000,
    parameter int unsigned RESET_CYC  = 5,
    localparam int unsigned IW = $clog2(NDEV + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            tdo_i,
    output logic            tck_o,
    output logic            tms_o,
    output logic            tdi_o,
    output logic            done_o,
    output logic            pass_o,
    output logic [NDEV-1:0] fail_o,
    output logic [IW-1:0]   break_idx_o
);
    // Total bits in one pass over the chain.
    function automatic int unsigned chain_bits();
        int unsigned s;
        s = 0;
        for (int i = 0; i < NDEV; i++) s += int'(DEV_LEN[i]);
        return s;
    endfunction

    localparam int unsigned TOTAL = chain_bits();
    localparam int unsigned HALF  = half_period(SYS_HZ, TCK_MAX_HZ);
    localparam int          SW    = $clog2(TOTAL + 1);

    logic busy;
    logic rise;
    logic fall;
    logic bit_vld;
    logic clear;
    logic finish;
    logic done_q;

    scp_tck_div #(.HALF(HALF)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .tck_o  (tck_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    scp_tap_walker #(.TOTAL(TOTAL), .RESET_CYC(RESET_CYC)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rise_i    (rise),
        .fall_i    (fall),
        .busy_o    (busy),
        .tms_o     (tms_o),
        .bit_vld_o (bit_vld),
        .clear_o   (clear),
        .finish_o  (finish)
    );

    scp_field_check #(
        .NDEV(NDEV), .MAXW(MAXW), .LENW(LENW), .IW(IW),
        .DEV_LEN(DEV_LEN), .DEV_EXP(DEV_EXP), .DEV_MASK(DEV_MASK)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .bit_vld_i (bit_vld),
        .bit_i     (tdo_i),
        .finish_i  (finish),
        .fail_o    (fail_o),
        .pass_o    (pass_o),
        .brk_o     (break_idx_o)
    );

    // Completion flag: cleared by an accepted start, set when the pass parks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            done_q <= 1'b0;
        else if (finish)
            done_q <= 1'b1;
    end

    assign done_o = done_q;
    assign tdi_o  = 1'b0;

    // Checker state: samples taken since the last accepted start.
    logic [SW-1:0] samp_q;

    // Count the sampled bits of the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            samp_q <= '0;
        else if (bit_vld && samp_q != SW'(TOTAL))
            samp_q <= samp_q + 1'b1;
    end

    // R3: the select line is steady for the whole high phase of the clock.
    p_tms_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_o && $past(tck_o)) |-> $stable(tms_o));

    // R5: a pass ends having taken exactly one sample per chain bit.
    p_sample_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> samp_q == SW'(TOTAL));

    // R9: with results shown, the test clock is parked low.
    p_parked_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tck_o);

    // R10: a start during a pass does not end or restart it.
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i && !finish) |=> busy && !done_o);

endmodule

// File: tb/tb_scan_chain_probe.sv
// Bench: scoreboard-style check of the scan chain integrity checker against a
// behavioural chain of three port state machines that can be cut at any link.
module tb_scan_chain_probe;

    localparam int NDEV  = 3;
    localparam int TOT   = 65;
    localparam int HALF  = 28;
    localparam int EDGES = 76;

    typedef enum int {
        T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUSEDR, T_EX2DR, T_UPDR,
        T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUSEIR, T_EX2IR, T_UPIR
    } tap_e;

    typedef struct {
        logic [2:0] fail;
        logic [1:0] brk;
        logic       pass;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tdo = 1'b1;
    logic tck, tms, tdi, done, pass;
    logic [2:0] fail;
    logic [1:0] brk;

    always #2 clk = ~clk;

    scan_chain_probe dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .tdo_i       (tdo),
        .tck_o       (tck),
        .tms_o       (tms),
        .tdi_o       (tdi),
        .done_o      (done),
        .pass_o      (pass),
        .fail_o      (fail),
        .break_idx_o (brk)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int          dlen  [NDEV] = '{32, 1, 32};
    logic [31:0] dexp  [NDEV] = '{32'h1000502F, 32'h0, 32'h09504093};
    logic [31:0] dmask [NDEV] = '{32'hFFFFFFFF, 32'h1, 32'h0FFFFFFF};

    logic [31:0] cap [NDEV];
    int          cut = NDEV;
    logic [TOT-1:0] chain;
    tap_e tap = T_TLR;

    int   edge_cnt = 0;
    int   shift_cnt = 0;
    int   tdi_bad = 0;
    int   period_bad = 0;
    longint cyc = 0;
    longint last_rise = 0;
    logic tms_log [0:EDGES+7];

    exp_t sb_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:     return m ? T_TLR     : T_RTI;
            T_RTI:     return m ? T_SELDR   : T_RTI;
            T_SELDR:   return m ? T_SELIR   : T_CAPDR;
            T_CAPDR:   return m ? T_EX1DR   : T_SHDR;
            T_SHDR:    return m ? T_EX1DR   : T_SHDR;
            T_EX1DR:   return m ? T_UPDR    : T_PAUSEDR;
            T_PAUSEDR: return m ? T_EX2DR   : T_PAUSEDR;
            T_EX2DR:   return m ? T_UPDR    : T_SHDR;
            T_UPDR:    return m ? T_SELDR   : T_RTI;
            T_SELIR:   return m ? T_TLR     : T_CAPIR;
            T_CAPIR:   return m ? T_EX1IR   : T_SHIR;
            T_SHIR:    return m ? T_EX1IR   : T_SHIR;
            T_EX1IR:   return m ? T_UPIR    : T_PAUSEIR;
            T_PAUSEIR: return m ? T_EX2IR   : T_PAUSEIR;
            T_EX2IR:   return m ? T_UPIR    : T_SHIR;
            default:   return m ? T_SELDR   : T_RTI;
        endcase
    endfunction

    // Expected TMS at rising edge i of a pass (R3).
    function automatic logic tms_expect(int i);
        if (i < 5) return 1'b1;
        if (i == 5) return 1'b0;
        if (i == 6) return 1'b1;
        if (i == 7 || i == 8) return 1'b0;
        if (i < 74) return (i == 73);
        if (i == 74) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) cyc++;

    // Chain model: port state machines advance and shift on rising edges.
    always @(posedge tck) begin
        if (edge_cnt < EDGES + 8) tms_log[edge_cnt] = tms;
        if (edge_cnt > 0 && (cyc - last_rise) != 2 * HALF) period_bad++;
        last_rise = cyc;
        edge_cnt++;
        if (tdi !== 1'b0) tdi_bad++;
        if (tap == T_CAPDR) begin
            int off;
            off = 0;
            for (int d = 0; d < NDEV; d++) begin
                for (int b = 0; b < dlen[d]; b++)
                    chain[off + b] = (d >= cut) ? 1'b1 : cap[d][b];
                off += dlen[d];
            end
        end else if (tap == T_SHDR) begin
            chain = {(cut < NDEV) ? 1'b1 : tdi, chain[TOT-1:1]};
            shift_cnt++;
        end
        tap = tap_next(tap, tms);
    end

    // Chain output changes on falling edges.
    always @(negedge tck) tdo = (tap == T_SHDR) ? chain[0] : 1'b1;

    // Monitor: compare results against the scoreboard when done rises.
    logic done_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done && !done_d) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(fail == e.fail, "R7", {e.tag, " fail vector"}, fail, e.fail);
                chk(pass == e.pass, "R7", {e.tag, " pass flag"}, pass, e.pass);
                chk(brk == e.brk, "R8", {e.tag, " break index"}, brk, e.brk);
                chk(tck == 1'b0, "R9", {e.tag, " clock parked"}, tck, 0);
            end
        end
        done_d = done;
    end

    // Driver: set the chain scenario, push expectations, run one pass.
    task automatic run_pass(input logic [31:0] c0, input logic [31:0] c1,
                            input logic [31:0] c2, input int k,
                            input bit poke, input string tag);
        exp_t e;
        logic [31:0] obs, lm;
        cap[0] = c0; cap[1] = c1; cap[2] = c2; cut = k;
        e.fail = '0;
        e.brk  = 2'(NDEV);
        for (int d = 0; d < NDEV; d++) begin
            obs = (d >= k) ? 32'hFFFFFFFF : cap[d];
            lm  = (dlen[d] >= 32) ? 32'hFFFFFFFF : ((32'd1 << dlen[d]) - 1);
            e.fail[d] = |((obs ^ dexp[d]) & dmask[d] & lm);
        end
        for (int d = NDEV - 1; d >= 0; d--) if (e.fail[d]) e.brk = 2'(d);
        e.pass = (e.fail == '0);
        e.tag  = tag;
        sb_q.push_back(e);

        edge_cnt = 0; shift_cnt = 0; tdi_bad = 0; period_bad = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0 && pass == 1'b0 && fail == 3'b000 && brk == 2'd3,
            "R11", {tag, " results cleared by start"}, {done, pass, fail, brk}, 6'b000011);
        if (poke) begin
            repeat (1500) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(edge_cnt == EDGES, "R3", {tag, " rising edge count"}, edge_cnt, EDGES);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < EDGES; i++) if (tms_log[i] !== tms_expect(i)) bad++;
            chk(bad == 0, "R3", {tag, " TMS sequence"}, bad, 0);
        end
        chk(tap == T_RTI, "R3", {tag, " chain ends in idle"}, tap, T_RTI);
        chk(tdi_bad == 0, "R4", {tag, " zero fill"}, tdi_bad, 0);
        chk(period_bad == 0, "R2", {tag, " clock period"}, period_bad, 0);
        chk(shift_cnt == TOT, "R5", {tag, " shift edges"}, shift_cnt, TOT);
        chk(done && !tck, "R9", {tag, " done held, clock low"}, {done, tck}, 2'b10);
        chk(sb_q.size() == 0, "R7", {tag, " result delivered"}, sb_q.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(tck == 0 && tms == 1 && tdi == 0 && done == 0 && pass == 0
            && fail == 0 && brk == 2'd3, "R1", "state during reset",
            {tck, tms, tdi, done, pass, fail, brk}, 9'b010000011);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tck == 0 && tms == 1 && done == 0 && brk == 2'd3, "R1",
            "state after reset", {tck, tms, done, brk}, 5'b01011);

        // R6 R7: intact chain, version nibble as found.
        run_pass(32'h1000502F, 32'h0, 32'h29504093, NDEV, 0, "intact");
        // R6: version nibble fully different is masked out.
        run_pass(32'h1000502F, 32'h0, 32'hF9504093, NDEV, 0, "version masked");
        // R8: open link between device 0 and device 1.
        run_pass(32'h1000502F, 32'h0, 32'h09504093, 1, 0, "cut at link 1");
        // R8: open link between device 1 and device 2.
        run_pass(32'h1000502F, 32'h0, 32'h09504093, 2, 0, "cut at link 2");
        // R8: open at the output side of the whole chain.
        run_pass(32'h1000502F, 32'h0, 32'h09504093, 0, 0, "cut at output");
        // R5 R6: a single flipped LSB of device 0 (first bit out).
        run_pass(32'h1000502E, 32'h0, 32'h09504093, NDEV, 0, "first bit flipped");
        // R6: bypass bit wrong only.
        run_pass(32'h1000502F, 32'h1, 32'h09504093, NDEV, 0, "bypass flipped");
        // R10: second start during a pass is ignored.
        run_pass(32'h1000502F, 32'h0, 32'h09504093, NDEV, 1, "start while busy");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R9", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule